// File: doc/BRIEF.md
# Fuse Controller Register Front-End

This block is the bus side of a one-time-programmable fuse controller. It decodes a 32-bit register bus into a control/status word (with a bit-set alias and a bit-clear alias), a timing word for the fuse engine, a program-data word and a window of shadow words. Each shadow word holds a copy of one fuse word. The block does not touch the fuses itself. It hands program and shadow-reload requests to a separate engine, and that engine reports completion with a done pulse and refills the shadows through a fill port.

Software starts a program in two steps. It first loads the control word with the unlock key and the target word address, then writes the data word. If the control word holds the key and the controller is idle with no pending error, the write is accepted: the address and data are latched for the engine and the key is wiped. A target word that is locked, a bus write to a shadow while a reload runs, a write to a locked shadow and a read of a read-protected shadow all set a sticky error flag and start nothing. Software clears that flag through the clear alias.

Top module: `fuse_reg_frontend`

## Requirements
- R1: After reset the control word reads 0 and `prog_req`, `reload_req` and `op_busy` are low.
- R2: The control word is at byte offset 0x00. Bits [6:0] are the word address, bit 8 BUSY, bit 9 ERROR, bit 10 RELOAD and bits [31:16] the key field. A plain write there loads the address and key fields. A write at 0x04 ORs the address/key bits in. A write at 0x08 clears the address/key bits that are 1 in the data. Reads at 0x00, 0x04 and 0x08 all return the control word.
- R3: A write to the data word (0x20) with key 0x3E77, not busy, ERROR clear and the addressed word unlocked is accepted. One cycle later `prog_req` pulses for one cycle, `op_busy` is high, `prog_addr` equals the address field, `prog_data` equals the written data and the key field reads 0.
- R4: While BUSY is set, control-word address writes leave `prog_addr` unchanged. Data-word writes are ignored, and the data word reads back the accepted value.
- R5: An otherwise valid program aimed at a word marked in `wr_lock` raises no request, leaves BUSY clear, sets ERROR and clears the key field.
- R6: ERROR stays set until a write to 0x08 with bit 9 set. While ERROR is set, a program write is ignored and the key field is kept.
- R7: A data-word write while the key field is not 0x3E77 raises no request and changes neither BUSY nor ERROR.
- R8: A write to 0x04 with bit 10 set while not busy pulses `reload_req` and sets RELOAD and BUSY. While busy, such a write is ignored. `eng_done` clears BUSY and RELOAD.
- R9: Shadow word i sits at 0x400 + 16*i. A bus write to it stores the data, except while RELOAD is set or when `wr_lock[i]` is set. In both of those cases the shadow is unchanged and ERROR is set.
- R10: A read of shadow i with `rd_lock[i]` set returns 0xBADABADA and sets ERROR.
- R11: `fill_en` writes `fill_data` into shadow `fill_idx`, and later bus reads return it.
- R12: Read data appears on `bus_rdata` the cycle after `bus_rd`. The timing word (0x10) reads back and drives `timing_cfg`. Unmapped or misaligned offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| wr_lock | input | NWORDS | Per-word program/shadow-write lock |
| rd_lock | input | NWORDS | Per-word read protection |
| prog_req | output | 1 | One-cycle program request to the engine |
| prog_addr | output | 7 | Latched program word address |
| prog_data | output | 32 | Latched program data |
| reload_req | output | 1 | One-cycle shadow-reload request |
| timing_cfg | output | 32 | Timing word for the engine |
| op_busy | output | 1 | BUSY flag |
| eng_done | input | 1 | Engine finished the current operation |
| fill_en | input | 1 | Engine shadow fill strobe |
| fill_idx | input | $clog2(NWORDS) | Shadow index to fill |
| fill_data | input | 32 | Fill data |

## Verification
Some properties are checked on every cycle. A request is a single-cycle pulse, and it comes only from a data-word write. Every request coincides with BUSY. The latched address and data hold still while BUSY stays up. ERROR falls only on a clear-alias write. The gating conditions can only be shown by the bench's scenarios, because they depend on register history: key present or absent, locked targets, an error that blocks a program, shadow writes during a reload, read-protected words and the alias arithmetic. Random shadow traffic and alias updates checked against a model in the bench cover the storage paths.

// File: rtl/fuse_fe_pkg.sv
package fuse_fe_pkg;
  localparam int OFS_CTRL    = 'h000;
  localparam int OFS_SET     = 'h004;
  localparam int OFS_CLR     = 'h008;
  localparam int OFS_TIMING  = 'h010;
  localparam int OFS_DATA    = 'h020;
  localparam int SHADOW_BASE = 'h400;
  localparam int SHADOW_SHIFT = 4;
  localparam int WADDR_W     = 7;
  localparam int BIT_RELOAD  = 10;
  localparam int BIT_ERR     = 9;
  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
  localparam logic [31:0] RD_PROTECT_WORD = 32'hBADABADA;

  typedef enum logic [1:0] {SRC_REG, SRC_SHADOW, SRC_PROT} rd_src_e;
endpackage

// File: rtl/fuse_ctrl_unit.sv
module fuse_ctrl_unit
  import fuse_fe_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ctrl_wr,
  input  logic               set_wr,
  input  logic               clr_wr,
  input  logic               timing_wr,
  input  logic               data_wr,
  input  logic [WADDR_W-1:0] wd_addr,
  input  logic [15:0]        wd_key,
  input  logic               wd_reload,
  input  logic               wd_err,
  input  logic [31:0]        wd_full,
  input  logic               target_locked,
  input  logic               viol,
  input  logic               eng_done,
  output logic [31:0]        ctrl_word,
  output logic [WADDR_W-1:0] addr_field,
  output logic [31:0]        timing_q,
  output logic [31:0]        data_q,
  output logic [WADDR_W-1:0] prog_addr_q,
  output logic               prog_req_q,
  output logic               reload_req_q,
  output logic               busy_q,
  output logic               err_q,
  output logic               reload_q
);
  logic [15:0] key_q;
  logic        key_ok;

  assign key_ok     = (key_q == UNLOCK_KEY);
  assign addr_field = addr_q;
  logic [WADDR_W-1:0] addr_q;

  assign ctrl_word = {key_q, 5'd0, reload_q, err_q, busy_q, 1'b0, addr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q       <= '0;
      key_q        <= '0;
      busy_q       <= 1'b0;
      err_q        <= 1'b0;
      reload_q     <= 1'b0;
      timing_q     <= '0;
      data_q       <= '0;
      prog_addr_q  <= '0;
      prog_req_q   <= 1'b0;
      reload_req_q <= 1'b0;
    end else begin
      prog_req_q   <= 1'b0;
      reload_req_q <= 1'b0;
      if (ctrl_wr) begin
        addr_q <= wd_addr;
        key_q  <= wd_key;
      end
      if (set_wr) begin
        addr_q <= addr_q | wd_addr;
        key_q  <= key_q | wd_key;
        if (wd_reload && !busy_q) begin
          reload_q     <= 1'b1;
          busy_q       <= 1'b1;
          reload_req_q <= 1'b1;
        end
      end
      if (clr_wr) begin
        addr_q <= addr_q & ~wd_addr;
        key_q  <= key_q & ~wd_key;
        if (wd_err) err_q <= 1'b0;
      end
      if (timing_wr) timing_q <= wd_full;
      if (data_wr && !busy_q && !err_q && key_ok) begin
        key_q <= '0;
        if (target_locked) begin
          err_q <= 1'b1;
        end else begin
          data_q      <= wd_full;
          prog_addr_q <= addr_q;
          busy_q      <= 1'b1;
          prog_req_q  <= 1'b1;
        end
      end
      if (viol) err_q <= 1'b1;
      if (eng_done && busy_q) begin
        busy_q   <= 1'b0;
        reload_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank #(
  parameter int NWORDS = 128,
  localparam int IW = $clog2(NWORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [31:0]   wdata,
  input  logic          re,
  input  logic [IW-1:0] ridx,
  output logic [31:0]   rdata_q
);
  logic [31:0] mem [NWORDS];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[ridx];
  end
endmodule

// File: rtl/fuse_reg_frontend.sv
module fuse_reg_frontend
  import fuse_fe_pkg::*;
#(
  parameter int NWORDS = 128,
  parameter int ADDR_W = 12,
  localparam int IW = $clog2(NWORDS),
  localparam int SIDX_W = ADDR_W - SHADOW_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NWORDS-1:0]  wr_lock,
  input  logic [NWORDS-1:0]  rd_lock,
  output logic               prog_req,
  output logic [WADDR_W-1:0] prog_addr,
  output logic [31:0]        prog_data,
  output logic               reload_req,
  output logic [31:0]        timing_cfg,
  output logic               op_busy,
  input  logic               eng_done,
  input  logic               fill_en,
  input  logic [IW-1:0]      fill_idx,
  input  logic [31:0]        fill_data
);
  logic is_ctrl, is_set, is_clr, is_timing, is_data, is_sh;
  logic [SIDX_W-1:0] sh_off;
  logic [IW-1:0]     sh_idx;
  logic              sh_wr_viol, sh_wr_ok, sh_rd_viol;
  logic [31:0]       ctrl_word, data_q, reg_mux, rd_hold, sh_q;
  logic [WADDR_W-1:0] addr_field;
  logic              target_locked, err_flag, reload_flag;
  rd_src_e           rd_src;

  assign is_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
  assign is_set    = (bus_addr == ADDR_W'(OFS_SET));
  assign is_clr    = (bus_addr == ADDR_W'(OFS_CLR));
  assign is_timing = (bus_addr == ADDR_W'(OFS_TIMING));
  assign is_data   = (bus_addr == ADDR_W'(OFS_DATA));

  assign sh_off = bus_addr[ADDR_W-1:SHADOW_SHIFT] - SIDX_W'(SHADOW_BASE >> SHADOW_SHIFT);
  assign sh_idx = sh_off[IW-1:0];
  assign is_sh  = (int'(bus_addr) >= SHADOW_BASE) && (bus_addr[SHADOW_SHIFT-1:0] == '0)
                  && (int'(sh_off) < NWORDS);

  assign sh_wr_viol = bus_wr && is_sh && (reload_flag || wr_lock[sh_idx]);
  assign sh_wr_ok   = bus_wr && is_sh && !(reload_flag || wr_lock[sh_idx]);
  assign sh_rd_viol = bus_rd && is_sh && rd_lock[sh_idx];

  assign target_locked = (int'(addr_field) >= NWORDS) || wr_lock[addr_field[IW-1:0]];

  fuse_ctrl_unit u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .ctrl_wr      (bus_wr && is_ctrl),
    .set_wr       (bus_wr && is_set),
    .clr_wr       (bus_wr && is_clr),
    .timing_wr    (bus_wr && is_timing),
    .data_wr      (bus_wr && is_data),
    .wd_addr      (bus_wdata[WADDR_W-1:0]),
    .wd_key       (bus_wdata[31:16]),
    .wd_reload    (bus_wdata[BIT_RELOAD]),
    .wd_err       (bus_wdata[BIT_ERR]),
    .wd_full      (bus_wdata),
    .target_locked(target_locked),
    .viol         (sh_wr_viol || sh_rd_viol),
    .eng_done     (eng_done),
    .ctrl_word    (ctrl_word),
    .addr_field   (addr_field),
    .timing_q     (timing_cfg),
    .data_q       (data_q),
    .prog_addr_q  (prog_addr),
    .prog_req_q   (prog_req),
    .reload_req_q (reload_req),
    .busy_q       (op_busy),
    .err_q        (err_flag),
    .reload_q     (reload_flag)
  );

  assign prog_data = data_q;

  fuse_shadow_bank #(.NWORDS(NWORDS)) u_shadow (
    .clk    (clk),
    .we     (fill_en || sh_wr_ok),
    .widx   (fill_en ? fill_idx : sh_idx),
    .wdata  (fill_en ? fill_data : bus_wdata),
    .re     (bus_rd && is_sh),
    .ridx   (sh_idx),
    .rdata_q(sh_q)
  );

  always_comb begin
    reg_mux = '0;
    if (is_ctrl || is_set || is_clr) reg_mux = ctrl_word;
    else if (is_timing)              reg_mux = timing_cfg;
    else if (is_data)                reg_mux = data_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_src  <= SRC_REG;
      rd_hold <= '0;
    end else if (bus_rd) begin
      rd_hold <= reg_mux;
      if (is_sh) rd_src <= rd_lock[sh_idx] ? SRC_PROT : SRC_SHADOW;
      else       rd_src <= SRC_REG;
    end
  end

  always_comb begin
    case (rd_src)
      SRC_SHADOW: bus_rdata = sh_q;
      SRC_PROT:   bus_rdata = RD_PROTECT_WORD;
      default:    bus_rdata = rd_hold;
    endcase
  end
endmodule

// File: rtl/fuse_fe_checker.sv
module fuse_fe_checker
  import fuse_fe_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic               prog_req,
  input logic               reload_req,
  input logic [WADDR_W-1:0] prog_addr,
  input logic [31:0]        prog_data,
  input logic               op_busy,
  input logic               err,
  input logic               eng_done
);
  // R3
  prog_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    prog_req |=> !prog_req);
  // R3
  prog_busy_chk: assert property (@(posedge clk) disable iff (rst)
    prog_req |-> op_busy);
  // R3
  prog_src_chk: assert property (@(posedge clk) disable iff (rst)
    prog_req |-> $past(bus_wr && (bus_addr == ADDR_W'(OFS_DATA))));
  // R4
  addr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (op_busy && !eng_done) |=> $stable(prog_addr));
  // R4
  data_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (op_busy && !eng_done) |=> $stable(prog_data));
  // R8
  reload_busy_chk: assert property (@(posedge clk) disable iff (rst)
    reload_req |-> op_busy);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err && !(bus_wr && (bus_addr == ADDR_W'(OFS_CLR)) && bus_wdata[BIT_ERR])) |=> err);
  // R8
  req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(prog_req && reload_req));
endmodule

bind fuse_reg_frontend fuse_fe_checker #(.ADDR_W(ADDR_W)) u_fe_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .prog_req  (prog_req),
  .reload_req(reload_req),
  .prog_addr (prog_addr),
  .prog_data (prog_data),
  .op_busy   (op_busy),
  .err       (err_flag),
  .eng_done  (eng_done)
);

// File: tb/test_fuse_reg_frontend.sv
module test_fuse_reg_frontend;
  localparam int NW = 128;
  localparam int AW = 12;

  logic clk = 0;
  logic rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NW-1:0] wr_lock, rd_lock;
  logic prog_req, reload_req, op_busy;
  logic [6:0] prog_addr;
  logic [31:0] prog_data, timing_cfg;
  logic eng_done = 0, fill_en = 0;
  logic [6:0] fill_idx = '0;
  logic [31:0] fill_data = '0;

  int checks = 0, errors = 0;
  logic [31:0] model [NW];

  always #2.5 clk = ~clk;

  fuse_reg_frontend #(.NWORDS(NW), .ADDR_W(AW)) i_fuse_reg_frontend (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_lock(wr_lock), .rd_lock(rd_lock),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .reload_req(reload_req), .timing_cfg(timing_cfg), .op_busy(op_busy),
    .eng_done(eng_done), .fill_en(fill_en), .fill_idx(fill_idx), .fill_data(fill_data)
  );

  function automatic logic [31:0] cw(input logic [15:0] key, input logic rl,
                                     input logic er, input logic bz, input logic [6:0] a);
    return {key, 5'd0, rl, er, bz, 1'b0, a};
  endfunction

  function automatic logic [31:0] fillpat(input int i);
    return (32'(i) * 32'h01010101) ^ 32'hC0DE0000;
  endfunction

  function automatic logic [AW-1:0] sh_ofs(input int i);
    return AW'(32'h400 + 16 * i);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [6:0] m_addr;
    void'($urandom(32'd1234));
    wr_lock = '0; wr_lock[5] = 1'b1;
    rd_lock = '0; rd_lock[6] = 1'b1;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 busy", {31'd0, op_busy}, 0);
    chk("R1 prog_req", {31'd0, prog_req}, 0);
    chk("R1 reload_req", {31'd0, reload_req}, 0);
    rd(12'h000, v); chk("R1 ctrl", v, 0);

    // R12 timing word and unmapped reads
    wr(12'h010, 32'h12345678);
    rd(12'h010, v); chk("R12 timing rd", v, 32'h12345678);
    chk("R12 timing_cfg", timing_cfg, 32'h12345678);
    rd(12'h030, v); chk("R12 unmapped", v, 0);
    rd(12'h404, v); chk("R12 misaligned", v, 0);

    // R2 aliases
    wr(12'h000, 32'h3E770003);
    rd(12'h000, v); chk("R2 ctrl write", v, cw(16'h3E77, 0, 0, 0, 3));
    wr(12'h004, 32'h00000004);
    rd(12'h004, v); chk("R2 set alias", v, cw(16'h3E77, 0, 0, 0, 7));
    wr(12'h008, 32'h00000004);
    rd(12'h008, v); chk("R2 clr alias", v, cw(16'h3E77, 0, 0, 0, 3));

    // R3 accepted program
    wr(12'h020, 32'hA5A50001);
    chk("R3 prog_req", {31'd0, prog_req}, 1);
    chk("R3 prog_addr", {25'd0, prog_addr}, 3);
    chk("R3 prog_data", prog_data, 32'hA5A50001);
    chk("R3 busy", {31'd0, op_busy}, 1);
    @(negedge clk);
    chk("R3 pulse width", {31'd0, prog_req}, 0);
    rd(12'h000, v); chk("R3 key wiped", v, cw(0, 0, 0, 1, 3));

    // R4 frozen while busy
    wr(12'h000, 32'h3E770009);
    chk("R4 prog_addr frozen", {25'd0, prog_addr}, 3);
    wr(12'h020, 32'h0000FFFF);
    chk("R4 no request", {31'd0, prog_req}, 0);
    chk("R4 prog_data frozen", prog_data, 32'hA5A50001);
    rd(12'h020, v); chk("R4 data readback", v, 32'hA5A50001);
    done_pulse();
    chk("R8 done clears busy", {31'd0, op_busy}, 0);
    rd(12'h000, v); chk("R4 ctrl after done", v, cw(16'h3E77, 0, 0, 0, 9));
    wr(12'h008, 32'hFFFF0000);

    // R7 program without key
    wr(12'h020, 32'h00000011);
    chk("R7 no request", {31'd0, prog_req}, 0);
    chk("R7 not busy", {31'd0, op_busy}, 0);
    rd(12'h000, v); chk("R7 ctrl", v, cw(0, 0, 0, 0, 9));

    // R5 locked target
    wr(12'h000, 32'h3E770005);
    wr(12'h020, 32'h00000022);
    chk("R5 no request", {31'd0, prog_req}, 0);
    chk("R5 not busy", {31'd0, op_busy}, 0);
    rd(12'h000, v); chk("R5 ctrl", v, cw(0, 0, 1, 0, 5));

    // R6 sticky error blocks programs
    wr(12'h000, 32'h3E770009);
    wr(12'h020, 32'h00000033);
    chk("R6 blocked request", {31'd0, prog_req}, 0);
    rd(12'h000, v); chk("R6 ctrl err kept", v, cw(16'h3E77, 0, 1, 0, 9));
    wr(12'h008, 32'h00000200);
    rd(12'h000, v); chk("R6 err cleared", v, cw(16'h3E77, 0, 0, 0, 9));
    wr(12'h020, 32'h00000044);
    chk("R6 accepted after clear", {31'd0, prog_req}, 1);
    chk("R6 prog_addr", {25'd0, prog_addr}, 9);
    done_pulse();

    // R8 reload
    wr(12'h004, 32'h00000400);
    chk("R8 reload_req", {31'd0, reload_req}, 1);
    chk("R8 busy", {31'd0, op_busy}, 1);
    rd(12'h000, v); chk("R8 ctrl", v, cw(0, 1, 0, 1, 9));
    wr(12'h004, 32'h00000400);
    chk("R8 ignored while busy", {31'd0, reload_req}, 0);

    // R11 engine fill
    for (int i = 0; i < NW; i++) begin
      @(negedge clk); fill_en = 1; fill_idx = 7'(i); fill_data = fillpat(i);
      model[i] = fillpat(i);
    end
    @(negedge clk); fill_en = 0;

    // R9 write during reload
    wr(sh_ofs(2), 32'h0000DEAD);
    rd(12'h000, v); chk("R9 err on reload write", v, cw(0, 1, 1, 1, 9));
    done_pulse();
    rd(12'h000, v); chk("R8 reload cleared", v, cw(0, 0, 1, 0, 9));
    rd(sh_ofs(2), v); chk("R9 shadow unchanged", v, fillpat(2));
    wr(12'h008, 32'h00000200);

    // R9 locked shadow
    wr(sh_ofs(5), 32'h0000BEEF);
    rd(12'h000, v); chk("R9 err on locked write", v, cw(0, 0, 1, 0, 9));
    rd(sh_ofs(5), v); chk("R9 locked unchanged", v, fillpat(5));
    wr(12'h008, 32'h00000200);

    // R10 read-protected shadow
    rd(sh_ofs(6), v); chk("R10 protect pattern", v, 32'hBADABADA);
    rd(12'h000, v); chk("R10 err set", v, cw(0, 0, 1, 0, 9));
    wr(12'h008, 32'h00000200);

    // R11 fill readback at edges
    rd(sh_ofs(0), v); chk("R11 word 0", v, fillpat(0));
    rd(sh_ofs(NW - 1), v); chk("R11 last word", v, fillpat(NW - 1));

    // R9 / R2 random traffic
    m_addr = 7'd9;
    for (int n = 0; n < 300; n++) begin
      int op, idx;
      logic [31:0] d;
      op = int'($urandom_range(0, 2));
      idx = int'($urandom_range(0, NW - 1));
      if (idx == 5 || idx == 6) idx = 0;
      d = $urandom;
      if (op == 0) begin
        wr(sh_ofs(idx), d);
        model[idx] = d;
      end else if (op == 1) begin
        rd(sh_ofs(idx), v); chk("R9 random shadow", v, model[idx]);
      end else begin
        if (d[31]) begin wr(12'h004, {25'd0, d[6:0]}); m_addr = m_addr | d[6:0]; end
        else       begin wr(12'h008, {25'd0, d[6:0]}); m_addr = m_addr & ~d[6:0]; end
        rd(12'h000, v); chk("R2 random alias", v, cw(0, 0, 0, 0, m_addr));
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule